// File: doc/BRIEF.md
# Clock Source Ready and Interrupt Register Block

This block is the software-visible face of a reset-and-clock controller. Eight clock sources are modelled:
- multi-speed internal oscillator (MSI)
- high-speed internal oscillator (HSI)
- high-speed external oscillator (HSE)
- low-speed internal oscillator (LSI)
- low-speed external oscillator (LSE)
- main PLL
- two auxiliary PLLs (AX1, AX2)

Software turns a source on by writing its on bit. The block then reports the source as ready after a programmable settling delay. Real oscillators are not modelled. The settling delay is one shared count register; a count of zero makes a source ready on the cycle after it is switched on.

Each source has an interrupt enable bit and a sticky interrupt flag. A flag is set only when that source's ready flag rises while its enable is set. A write-one-to-clear register removes flags. One shared level interrupt output combines all eight sources.

A two-bit system clock request field has a matching status field. The status takes the requested value only once the requested source is ready. A main-PLL configuration register holds a multiplier, an output enable and a source select.

The block also holds a range field for the multi-speed oscillator. That field is write-protected while the oscillator is settling.

Access is a simple 32-bit bus:
- A write happens at the clock edge where `wr_i` is high.
- Read data is combinational from `addr_i`.

Register map, byte offsets (the block decodes `addr_i[5:2]`):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | CTRL | Bit pairs (on, ready): MSI 0/1, HSI 2/3, HSE 4/5, PLL 6/7, AX1 8/9, AX2 10/11. MSI range in bits 15:12. |
| 0x04 | CFG | Request in [1:0], status in [3:2]. |
| 0x08 | PLLCFG | Source select [1:0], multiplier N [14:8], output enable bit 16. |
| 0x0C | LSI | On bit 0, ready bit 1. |
| 0x10 | BACKUP | LSE on bit 0, LSE ready bit 1, drive strength [4:3]. |
| 0x14 | IEN | Interrupt enables. |
| 0x18 | IFLAG | Interrupt flags, read-only. |
| 0x1C | ICLR | Write-one-to-clear for the flags; reads as 0. |
| 0x20 | DELAY | Settling count [7:0]. |

The interrupt registers (IEN, IFLAG, ICLR) use one bit per source, by source index:

| Bit | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 |
|---|---|---|---|---|---|---|---|---|
| Source | MSI | HSI | HSE | LSI | LSE | PLL | AX1 | AX2 |

Top module: `clk_ready_ctrl`

## Requirements
- R1: After reset, CTRL reads 0x4003: MSI on and ready, MSI range 4, everything else off. CFG, PLLCFG, LSI, BACKUP, IEN, IFLAG and DELAY read 0, and `irq_o` is 0.
- R2: If a source's on bit is written to 1 at edge k, its ready bit reads 1 from edge k+1+D, where D is the DELAY count at that time. With D=0 the source is ready one cycle after the write. Ready bits in written data are ignored.
- R3: If an on bit is written to 0 at edge k, the ready bit reads 0 from edge k+1. No interrupt flag is set by this.
- R4: A source's IFLAG bit is set at the same edge its ready bit rises, but only if its IEN bit is 1. Rewriting the on bit of a source that is already ready sets no flag.
- R5: Writing 1 to an ICLR bit clears that IFLAG bit. Writing 0 leaves it unchanged. A write to IFLAG itself changes nothing. If a clear and a new rise of the same bit meet at one edge, the flag stays set.
- R6: `irq_o` is 1 exactly when some source has both its IFLAG bit and its IEN bit set.
- R7: The CFG request encoding is 0 = MSI, 1 = HSI, 2 = HSE, 3 = PLL. The status field takes the request value at the first edge at which the requested source is already ready. Until then it keeps its old value.
- R8: PLLCFG stores source select [1:0] (01 = MSI), N [14:8] and output enable bit 16. Other bits read 0.
- R9: A CTRL write updates the MSI range only when MSI is off or ready at that edge. Otherwise the range is unchanged.
- R10: LSI on/ready live in the LSI register. LSE on/ready and the 2-bit drive field live in the BACKUP register. Both follow the same ready and interrupt rules as the other sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Shared ready interrupt |

## Verification
Two functions can fall on the same clock edge: a write-one-to-clear of a flag, and a fresh ready rise of the same source. The bench provokes this with a zero settling delay. It switches the main PLL on and writes ICLR with the PLL bit on the very next edge, which is the edge where PLL ready rises. It then expects the flag to survive and the interrupt output to stay high. A second collision is a switch request made while its target is still settling. For that case the bench reads the status field on every edge and expects it to change exactly one edge after the target's ready bit rises.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  localparam int N_SRC = 8;

  // Source index; also the bit position in IEN, IFLAG and ICLR
  localparam int S_MSI = 0;
  localparam int S_HSI = 1;
  localparam int S_HSE = 2;
  localparam int S_LSI = 3;
  localparam int S_LSE = 4;
  localparam int S_PLL = 5;
  localparam int S_AX1 = 6;
  localparam int S_AX2 = 7;

  // Word index of each register (addr_i[5:2])
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_CFG    = 4'd1;
  localparam logic [3:0] A_PLLCFG = 4'd2;
  localparam logic [3:0] A_LSI    = 4'd3;
  localparam logic [3:0] A_BKP    = 4'd4;
  localparam logic [3:0] A_IEN    = 4'd5;
  localparam logic [3:0] A_IFLAG  = 4'd6;
  localparam logic [3:0] A_ICLR   = 4'd7;
  localparam logic [3:0] A_DLY    = 4'd8;

  typedef enum logic [1:0] {
    CK_MSI = 2'b00,
    CK_HSI = 2'b01,
    CK_HSE = 2'b10,
    CK_PLL = 2'b11
  } ck_sel_e;
endpackage

// File: rtl/ckc_osc.sv
module ckc_osc #(
  parameter int DLY_W  = 8,
  parameter bit RST_ON = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             on_d_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             on_o,
  output logic             rdy_o,
  output logic             rise_o
);
  logic             on_q, rdy_q;
  logic [DLY_W-1:0] cnt_q;
  logic             done;

  assign done   = cnt_q >= dly_i;
  assign rise_o = on_q & ~rdy_q & done;
  assign on_o   = on_q;
  assign rdy_o  = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= RST_ON;
      rdy_q <= RST_ON;
      cnt_q <= '0;
    end else begin
      if (wr_i) on_q <= on_d_i;
      if (!on_q) begin
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end else if (!rdy_q) begin
        if (done) rdy_q <= 1'b1;
        else      cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_rdy_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q && rdy_q) |=> !rdy_q);

  p_rdy_needs_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_q |=> (!rdy_q || $past(on_q)));
endmodule

// File: rtl/ckc_irq.sv
module ckc_irq #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_wr_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, flag_q, clr_m, set_m;

  assign clr_m = clr_wr_i ? wdata_i : '0;
  assign set_m = rise_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i;
      flag_q <= (flag_q & ~clr_m) | set_m;  // set wins over clear
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_q);

  p_flag_only_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rise_i & en_q)) == '0));

  p_clear_takes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(clr_wr_i ? (wdata_i & ~(rise_i & en_q)) : '0)) == '0));
endmodule

// File: rtl/ckc_sysclk.sv
module ckc_sysclk
  import ckc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] sw_d_i,
  input  logic [3:0] rdy_i,   // indexed by ck_sel_e
  output logic [1:0] sw_o,
  output logic [1:0] sws_o
);
  ck_sel_e sw_q, sws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= CK_MSI;
      sws_q <= CK_MSI;
    end else begin
      if (wr_i) sw_q <= ck_sel_e'(sw_d_i);
      if (rdy_i[sw_q]) sws_q <= sw_q;
    end
  end

  assign sw_o  = sw_q;
  assign sws_o = sws_q;

  p_sws_to_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sws_q) |-> (sws_q == $past(sw_q)));

  p_sws_needs_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sws_q) |-> $past(rdy_i[sw_q]));
endmodule

// File: rtl/clk_ready_ctrl.sv
module clk_ready_ctrl
  import ckc_pkg::*;
#(
  parameter int DLY_W     = 8,
  parameter int N_W       = 7,
  parameter int RANGE_W   = 4,
  parameter int RANGE_RST = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int RANGE_LSB = 12;
  localparam int N_LSB     = 8;
  localparam int PREN_BIT  = 16;
  localparam int DRV_LSB   = 3;

  logic [3:0] a;
  assign a = addr_i[5:2];

  logic ctrl_wr, cfg_wr, pll_wr, lsi_wr, bkp_wr, ien_wr, iclr_wr, dly_wr;
  assign ctrl_wr = wr_i && (a == A_CTRL);
  assign cfg_wr  = wr_i && (a == A_CFG);
  assign pll_wr  = wr_i && (a == A_PLLCFG);
  assign lsi_wr  = wr_i && (a == A_LSI);
  assign bkp_wr  = wr_i && (a == A_BKP);
  assign ien_wr  = wr_i && (a == A_IEN);
  assign iclr_wr = wr_i && (a == A_ICLR);
  assign dly_wr  = wr_i && (a == A_DLY);

  logic [DLY_W-1:0]   dly_q;
  logic [RANGE_W-1:0] range_q;
  logic [1:0]         drv_q;
  logic [1:0]         psrc_q;
  logic [N_W-1:0]     pn_q;
  logic               pren_q;

  logic [N_SRC-1:0] src_wr, on_d, on, rdy, rise;

  // Per-source write strobe and on-bit position
  assign src_wr = {ctrl_wr, ctrl_wr, ctrl_wr, bkp_wr, lsi_wr, ctrl_wr, ctrl_wr, ctrl_wr};
  assign on_d   = {wdata_i[10], wdata_i[8], wdata_i[6], wdata_i[0],
                   wdata_i[0], wdata_i[4], wdata_i[2], wdata_i[0]};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    ckc_osc #(.DLY_W(DLY_W), .RST_ON(i == S_MSI)) u_osc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (src_wr[i]),
      .on_d_i (on_d[i]),
      .dly_i  (dly_q),
      .on_o   (on[i]),
      .rdy_o  (rdy[i]),
      .rise_o (rise[i])
    );
  end

  logic [N_SRC-1:0] ien, iflag;
  ckc_irq #(.N(N_SRC)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (ien_wr),
    .clr_wr_i (iclr_wr),
    .wdata_i  (wdata_i[N_SRC-1:0]),
    .rise_i   (rise),
    .en_o     (ien),
    .flag_o   (iflag),
    .irq_o    (irq_o)
  );

  logic [1:0] sw, sws;
  ckc_sysclk u_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr),
    .sw_d_i (wdata_i[1:0]),
    .rdy_i  ({rdy[S_PLL], rdy[S_HSE], rdy[S_HSI], rdy[S_MSI]}),
    .sw_o   (sw),
    .sws_o  (sws)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      range_q <= RANGE_W'(RANGE_RST);
      drv_q   <= '0;
      psrc_q  <= '0;
      pn_q    <= '0;
      pren_q  <= 1'b0;
    end else begin
      if (dly_wr) dly_q <= wdata_i[DLY_W-1:0];
      // range is locked while MSI is settling
      if (ctrl_wr && (!on[S_MSI] || rdy[S_MSI]))
        range_q <= wdata_i[RANGE_LSB +: RANGE_W];
      if (bkp_wr) drv_q <= wdata_i[DRV_LSB +: 2];
      if (pll_wr) begin
        psrc_q <= wdata_i[1:0];
        pn_q   <= wdata_i[N_LSB +: N_W];
        pren_q <= wdata_i[PREN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (a)
      A_CTRL: begin
        rdata_o[1:0]   = {rdy[S_MSI], on[S_MSI]};
        rdata_o[3:2]   = {rdy[S_HSI], on[S_HSI]};
        rdata_o[5:4]   = {rdy[S_HSE], on[S_HSE]};
        rdata_o[7:6]   = {rdy[S_PLL], on[S_PLL]};
        rdata_o[9:8]   = {rdy[S_AX1], on[S_AX1]};
        rdata_o[11:10] = {rdy[S_AX2], on[S_AX2]};
        rdata_o[RANGE_LSB +: RANGE_W] = range_q;
      end
      A_CFG:    rdata_o[3:0] = {sws, sw};
      A_PLLCFG: begin
        rdata_o[1:0]           = psrc_q;
        rdata_o[N_LSB +: N_W]  = pn_q;
        rdata_o[PREN_BIT]      = pren_q;
      end
      A_LSI:   rdata_o[1:0] = {rdy[S_LSI], on[S_LSI]};
      A_BKP: begin
        rdata_o[1:0]         = {rdy[S_LSE], on[S_LSE]};
        rdata_o[DRV_LSB +: 2] = drv_q;
      end
      A_IEN:   rdata_o[N_SRC-1:0] = ien;
      A_IFLAG: rdata_o[N_SRC-1:0] = iflag;
      A_DLY:   rdata_o[DLY_W-1:0] = dly_q;
      default: rdata_o = '0;
    endcase
  end

  p_range_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on[S_MSI] && !rdy[S_MSI]) |=> $stable(range_q));

  p_irq_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (iflag != '0));
endmodule

// File: tb/clk_ready_ctrl_test.sv
module clk_ready_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  clk_ready_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    bit          is_irq;
    logic [5:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit rd_act = 1'b0;
  bit done = 1'b0;

  localparam logic [5:0] CTRL = 6'h00, CFG = 6'h04, PLLC = 6'h08, LSI = 6'h0C,
                         BKP = 6'h10, IEN = 6'h14, IFL = 6'h18, ICLR = 6'h1C,
                         DLY = 6'h20;

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = t;
    addr_i = a;
    q.push_back(it);
    rd_act = 1'b1;
    @(posedge clk_i); #1;
    rd_act = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1'b1; it.a = '0; it.exp = {31'd0, e}; it.tag = t;
    q.push_back(it);
    rd_act = 1'b1;
    @(posedge clk_i); #1;
    rd_act = 1'b0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk_i) begin
    if (rd_act && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : rdata_o;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    rd(CTRL, 32'h4003, "R1 ctrl");
    rd(CFG, 32'h0, "R1 cfg");
    rd(PLLC, 32'h0, "R1 pllcfg");
    rd(LSI, 32'h0, "R1 lsi");
    rd(BKP, 32'h0, "R1 backup");
    rd(IEN, 32'h0, "R1 ien");
    rd(IFL, 32'h0, "R1 iflag");
    rd(DLY, 32'h0, "R1 delay");
    chk_irq(1'b0, "R1 irq");

    // R4 rewriting on of already-ready MSI raises nothing
    wr(IEN, 32'h01);
    wr(CTRL, 32'h4001);
    rd(IFL, 32'h0, "R4 msi already ready");
    chk_irq(1'b0, "R4 irq quiet");

    // R2 zero delay, HSI; R4 flag with enable
    wr(IEN, 32'h02);
    wr(CTRL, 32'h4005 | 32'h0002);
    rd(CTRL, 32'h4007, "R2 hsi not yet ready");
    rd(CTRL, 32'h400F, "R2 hsi ready next cycle");
    rd(IFL, 32'h02, "R4 hsi flag");
    chk_irq(1'b1, "R6 irq high");

    // R5 clear semantics
    wr(ICLR, 32'h0);
    rd(IFL, 32'h02, "R5 zero clear no effect");
    wr(IFL, 32'hFF);
    rd(IFL, 32'h02, "R5 iflag not writable");
    wr(ICLR, 32'h02);
    rd(IFL, 32'h0, "R5 clear");
    chk_irq(1'b0, "R6 irq low after clear");

    // R2 delay 3 on HSE with enable off
    wr(IEN, 32'h0);
    wr(DLY, 32'd3);
    wr(CTRL, 32'h4015);
    rd(CTRL, 32'h401F, "R2 hse wait 0");
    rd(CTRL, 32'h401F, "R2 hse wait 1");
    rd(CTRL, 32'h401F, "R2 hse wait 2");
    rd(CTRL, 32'h401F, "R2 hse wait 3");
    rd(CTRL, 32'h403F, "R2 hse ready after delay");
    rd(IFL, 32'h0, "R4 no flag without enable");
    wr(IEN, 32'h04);
    chk_irq(1'b0, "R6 enable alone no irq");

    // R3 turn HSE off
    wr(CTRL, 32'h400D);
    rd(CTRL, 32'h402F, "R3 ready still high");
    rd(CTRL, 32'h400F, "R3 ready dropped");
    rd(IFL, 32'h0, "R3 no flag on off");

    // R9 MSI range protection
    wr(DLY, 32'd5);
    wr(CTRL, 32'h400C);
    rd(CTRL, 32'h400E, "R9 msi ready lingers");
    rd(CTRL, 32'h400C, "R9 msi off");
    wr(CTRL, 32'h700C);
    rd(CTRL, 32'h700C, "R9 range written while off");
    wr(CTRL, 32'h200D);
    wr(CTRL, 32'h900D);
    rd(CTRL, 32'h200D, "R9 range locked while settling");
    repeat (10) @(posedge clk_i);
    #1;
    rd(CTRL, 32'h200F, "R9 msi ready again");
    wr(CTRL, 32'h900D);
    rd(CTRL, 32'h900F, "R9 range written while ready");
    rd(IFL, 32'h0, "R4 msi rise without enable");
    wr(DLY, 32'd0);

    // R7 switch request to not-ready HSE
    wr(CFG, 32'h2);
    rd(CFG, 32'h2, "R7 status holds");
    rd(CFG, 32'h2, "R7 status still holds");
    wr(CTRL, 32'h901D);
    rd(CTRL, 32'h901F, "R2 hse settling");
    rd(CFG, 32'h2, "R7 status one edge after ready");
    rd(CFG, 32'hA, "R7 status follows");
    rd(IFL, 32'h04, "R4 hse flag");
    chk_irq(1'b1, "R6 hse irq");

    // R5 clear colliding with a new PLL rise: set wins
    wr(IEN, 32'h24);
    wr(ICLR, 32'h04);
    wr(PLLC, 32'h0001_2801);
    rd(PLLC, 32'h0001_2801, "R8 pllcfg fields");
    wr(CTRL, 32'h905D);
    wr(ICLR, 32'h20);
    rd(IFL, 32'h20, "R5 set wins over clear");
    chk_irq(1'b1, "R6 pll irq");
    wr(ICLR, 32'h20);
    rd(IFL, 32'h0, "R5 pll clear");
    rd(CTRL, 32'h90FF, "R2 pll ready");

    // R8 unused bits
    wr(PLLC, 32'hFFFF_FFFF);
    rd(PLLC, 32'h0001_7F03, "R8 unused bits zero");
    wr(PLLC, 32'h0001_2801);

    // R7 switch to PLL (ready), then HSI
    wr(CFG, 32'h3);
    rd(CFG, 32'hB, "R7 pll request pending");
    rd(CFG, 32'hF, "R7 pll status");
    wr(CFG, 32'h1);
    rd(CFG, 32'hD, "R7 hsi request pending");
    rd(CFG, 32'h5, "R7 hsi status");

    // R10 LSI and LSE registers
    wr(IEN, 32'h08);
    wr(LSI, 32'h1);
    rd(LSI, 32'h1, "R10 lsi settling");
    rd(LSI, 32'h3, "R10 lsi ready");
    rd(IFL, 32'h08, "R10 lsi flag");
    wr(IEN, 32'h18);
    wr(BKP, 32'h1B);
    rd(BKP, 32'h19, "R10 lse settling");
    rd(BKP, 32'h1B, "R10 lse ready with drive");
    rd(IFL, 32'h18, "R10 lse flag");
    chk_irq(1'b1, "R6 low-speed irq");
    wr(ICLR, 32'h18);
    chk_irq(1'b0, "R6 irq cleared");
    rd(CTRL, 32'h90FF, "R10 ctrl untouched by low-speed");

    // auxiliary PLLs
    wr(IEN, 32'hC0);
    wr(CTRL, 32'h9555);
    rd(CTRL, 32'h95FF, "R2 aux settling");
    rd(CTRL, 32'h9FFF, "R2 aux ready");
    rd(IFL, 32'hC0, "R4 aux flags");
    wr(ICLR, 32'hC0);
    wr(CTRL, 32'h9555);
    rd(IFL, 32'h0, "R4 rewrite ready aux quiet");
    chk_irq(1'b0, "R6 irq quiet at end");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule